// File: doc/BRIEF.md
# Edge-Interval Serial Byte Receiver

This block receives asynchronous serial characters that have one low start bit, a configurable number of data bits sent least significant bit first, and a high stop bit. It does not sample each bit in the middle. It times the line between transitions. A high-to-low transition on the idle line arms a free-running interval counter. Each later transition closes an interval. The interval is rounded to a whole number of bit periods, and that many copies of the level that just ended are appended to the frame.

When no transition arrives before the middle of the stop bit, the block closes the frame on its own. This is needed because a run of ones at the end of the data merges with the stop bit and produces no closing edge. Any positions still undecided are filled with the present line level. The byte is presented with a one-cycle valid strobe. A framing flag reports a low line at the stop position. The bit period, in clock cycles, is an input, so the baud rate can be changed while the line is idle.

Top module: `edge_interval_rx`

## Requirements
- R1: While reset is low, and on the first cycle after it, `data_valid`, `frame_err` and `data_out` are all zero.
- R2: While no frame is in progress, a steady line or a low-to-high transition never produces `data_valid`. Only a high-to-low transition starts a frame.
- R3: `data_valid` is high for exactly one cycle. With P = `bit_period` and N = DATA_BITS, it rises exactly 3 + (N+1)·P + floor(P/2) clock cycles after the `rxd` falling edge that starts the frame. Two synchronizer stages and one edge register account for the 3.
- R4: `data_out[i]` equals the i-th bit after the start bit (bit 0 is sent first). It holds its value until the next `data_valid`.
- R5: Falling edges on `rxd` inside a frame do not restart the frame. For example, 0x55 decodes with the timing of R3.
- R6: Each interval between edges is converted to round((interval)/P) bits. A transmitter whose bit time is P−1 cycles still decodes correctly when P = 16.
- R7: Data bits after the last transition take the line level at completion. This covers bytes that end in ones, such as 0xFF and 0xF0.
- R8: `frame_err` is 1 when `rxd` is low at completion, which is the middle of the stop bit, and 0 otherwise. It changes only in the cycle `data_valid` is high.
- R9: Start detection is re-armed as soon as a frame completes. A frame whose start bit follows the previous stop bit with no idle gap is decoded.
- R10: `bit_period` is taken at run time. A period of 7 cycles, which is odd, decodes as well as 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rxd | input | 1 | Asynchronous serial line, idle high |
| bit_period | input | CNT_W | Bit time in clock cycles; change only while idle |
| data_out | output | DATA_BITS | Received character, LSB first on the line |
| data_valid | output | 1 | One-cycle strobe: `data_out` and `frame_err` are new |
| frame_err | output | 1 | Stop position was low in the last frame |

## Verification
Every result of this block falls due at one instant: 3 + (N+1)·P + floor(P/2) clock edges after the start edge is driven. The driver task records the cycle count when it drives the start bit. It pushes that deadline into the queue together with the expected byte and framing flag. The monitor pops an entry only when `data_valid` is seen, and it compares the cycle of arrival with the deadline as a check in its own right. This catches an early or late strobe as well as a wrong value. Any strobe that arrives with the queue empty is a failure, and so is any entry left in the queue at the end.

// File: rtl/edge_interval_rx.sv
module edge_interval_rx #(
  parameter int DATA_BITS = 8,
  parameter int CNT_W     = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rxd,
  input  logic [CNT_W-1:0]     bit_period,
  output logic [DATA_BITS-1:0] data_out,
  output logic                 data_valid,
  output logic                 frame_err
);
  localparam int NB = DATA_BITS + 1;
  localparam int TW = CNT_W + $clog2(NB + 2) + 1;

  logic          s1, s2, s3, busy;
  logic [TW-1:0] cnt, total, nb;
  logic [NB-1:0] bits_q, bits_app, bits_fill;

  wire [TW-1:0] per   = {{(TW-CNT_W){1'b0}}, bit_period};
  wire [TW-1:0] half  = per >> 1;
  wire [TW-1:0] width = cnt + 1'b1;
  wire [TW-1:0] runs  = (width + half) / per;
  wire [TW-1:0] limit = TW'(NB) * per + half;
  wire          edge_seen = s2 ^ s3;
  wire          done  = busy && (total + width >= limit);
  wire [TW-1:0] nb_sum  = nb + runs;
  wire [TW-1:0] nb_next = (nb_sum > TW'(NB)) ? TW'(NB) : nb_sum;

  always_comb begin
    for (int i = 0; i < NB; i++) begin
      bits_app[i]  = (TW'(i) >= nb && TW'(i) < nb_sum) ? s3 : bits_q[i];
      bits_fill[i] = (TW'(i) >= nb) ? s2 : bits_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b1; s2 <= 1'b1; s3 <= 1'b1;
      busy <= 1'b0; cnt <= '0; total <= '0; nb <= '0; bits_q <= '0;
      data_out <= '0; data_valid <= 1'b0; frame_err <= 1'b0;
    end else begin
      s1 <= rxd; s2 <= s1; s3 <= s2;
      data_valid <= 1'b0;
      if (!busy) begin
        if (s3 && !s2) begin
          busy <= 1'b1; cnt <= '0; total <= '0; nb <= '0;
        end
      end else if (done) begin
        busy       <= 1'b0;
        data_valid <= 1'b1;
        data_out   <= bits_fill[NB-1:1];
        frame_err  <= ~s2;
      end else if (edge_seen) begin
        cnt    <= '0;
        total  <= total + width;
        nb     <= nb_next;
        bits_q <= bits_app;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |=> !data_valid);  // R3
  AST_FRAME_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (total + cnt < limit));  // R3
  AST_VALID_FROM_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |-> $past(busy));  // R2
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !data_valid |-> $stable(data_out));  // R4
  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !data_valid |-> $stable(frame_err));  // R8
endmodule

// File: tb/test_edge_interval_rx.sv
`timescale 1ns/1ps
module test_edge_interval_rx;
  logic        clk = 1'b0, rst_n = 1'b0, rxd = 1'b1;
  logic [15:0] bit_period = 16'd16;
  logic [7:0]  data_out;
  logic        data_valid, frame_err;

  edge_interval_rx #(.DATA_BITS(8), .CNT_W(16)) i_edge_interval_rx (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .bit_period(bit_period),
    .data_out(data_out), .data_valid(data_valid), .frame_err(frame_err));

  always #2.5 clk = ~clk;

  typedef struct { logic [7:0] d; logic e; int due; string tag; } exp_t;
  exp_t q[$];
  int cyc = 0, checks = 0, errors = 0, seen = 0;
  bit finished = 0;

  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b, input bit stop, input int ps,
                      input int gap, input string tag);
    int p;
    p = int'(bit_period);
    @(negedge clk);
    q.push_back('{b, !stop, cyc + 3 + 9*p + p/2, tag});
    rxd = 1'b0;
    repeat (ps) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (ps) @(negedge clk);
    end
    rxd = stop;
    repeat (ps) @(negedge clk);
    repeat (gap) @(negedge clk);
    rxd = 1'b1;
  endtask

  always @(negedge clk) begin
    if (rst_n && data_valid) begin
      seen++;
      if (q.size() == 0) begin
        chk(0, "R2 unexpected data_valid", 1, 0);
      end else begin
        exp_t x;
        x = q.pop_front();
        chk(data_out == x.d, {x.tag, " R4 data"}, data_out, x.d);
        chk(frame_err == x.e, {x.tag, " R8 frame_err"}, frame_err, x.e);
        chk(cyc == x.due, {x.tag, " R3 timing"}, cyc, x.due);
      end
    end
  end

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    chk(0, "watchdog", 0, 1);
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(data_valid == 0 && frame_err == 0 && data_out == 0, "R1 reset", data_out, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(data_valid == 0 && frame_err == 0 && data_out == 0, "R1 after reset", data_out, 0);
    repeat (100) @(negedge clk);
    chk(seen == 0, "R2 idle line", seen, 0);

    send(8'h55, 1, 16, 32, "R5 alternating");
    send(8'h00, 1, 16, 32, "zeros");
    send(8'hFF, 1, 16, 32, "R7 ones");
    send(8'hF0, 1, 16, 32, "R7 high nibble");
    send(8'hA3, 1, 15, 32, "R6 slow-clock sender");
    send(8'h00, 0, 16, 40, "R8 break");
    repeat (60) @(negedge clk);
    chk(seen == 6, "R2 rising edge while idle", seen, 6);
    send(8'h3C, 1, 16, 0, "R9 back-to-back A");
    send(8'hC5, 1, 16, 40, "R9 back-to-back B");

    repeat (30) @(negedge clk);
    bit_period = 16'd7;
    repeat (10) @(negedge clk);
    send(8'hA3, 1, 7, 20, "R10 period 7");
    send(8'h0F, 1, 7, 20, "R10 low nibble");
    send(8'h81, 0, 7, 20, "R8 R10 low stop");

    repeat (200) @(negedge clk);
    chk(q.size() == 0, "R3 missing data_valid", q.size(), 0);
    report();
  end
endmodule